// File: doc/BRIEF.md
# Mixed-Sign Byte Multiply Execute Slice

This block is the execute-stage slice of an 8-bit microcontroller core that carries out one instruction: a multiply of a signed byte by an unsigned byte. When the issue strobe is raised with a 16-bit instruction word, two 3-bit operand fields are pulled out of that word. Each field is offset by a fixed window base of 16 to form a register-file read address. The register file returns both operands combinationally, and the slice captures them at the end of the issue cycle.

In the following cycle the slice forms the 16-bit two's-complement product. It drives it onto a dual write port aimed at a fixed register pair: the high byte goes to register 1 and the low byte to register 0. It also raises a done strobe that carries the instruction's cycle count. At the end of that cycle the carry and zero status flags take their new values, and they hold them until the next multiply completes. Widths, window base, field positions, destination pair, latency and the multiplier variant (direct or partial-product array) are parameters.

Top module: `mulsu_exec`

## Requirements
- R1: While `start` is high, `rd_addr_a` equals 16 plus instruction bits [6:4] and `rd_addr_b` equals 16 plus instruction bits [2:0], so both addresses lie in registers 16 to 23.
- R2: The operands returned on `rd_data_a` and `rd_data_b` during the issue cycle are multiplied as signed (a) times unsigned (b). The 16-bit two's-complement result appears on `wr_data_hi` (bits 15:8) and `wr_data_lo` (bits 7:0). This also holds when both fields name the same register.
- R3: The product is written with a single `wr_en` pulse one cycle after issue, with `wr_addr_hi` = 1 and `wr_addr_lo` = 0 in that same cycle. `wr_en` is low in every other cycle.
- R4: At the end of the write cycle `flag_c` takes bit 15 of the product.
- R5: At the end of the write cycle `flag_z` is set exactly when the 16-bit product is zero.
- R6: Outside write cycles both flags keep their values.
- R7: The instruction takes two cycles. `done` is high in the second cycle, with `op_cycles` = 2 and `busy` high.
- R8: A `start` that arrives while `busy` is high is ignored. No further write and no flag change follow it.
- R9: While `rst_n` is low, `busy`, `wr_en`, `done`, `flag_c`, `flag_z` and `op_cycles` are all 0.
- R10: No register other than 0 and 1 is changed by a multiply.
- R11: (-128) times 255 gives 0x8080, with carry 1 and zero 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for the multiply instruction |
| instr | input | 16 | Instruction word holding both operand fields |
| busy | output | 1 | Instruction in its execute cycle |
| rd_addr_a | output | 5 | Read address of the signed operand |
| rd_addr_b | output | 5 | Read address of the unsigned operand |
| rd_data_a | input | 8 | Signed operand from the register file |
| rd_data_b | input | 8 | Unsigned operand from the register file |
| wr_en | output | 1 | Write strobe for both bytes of the product |
| wr_addr_hi | output | 5 | Register receiving the high byte |
| wr_data_hi | output | 8 | Product bits 15:8 |
| wr_addr_lo | output | 5 | Register receiving the low byte |
| wr_data_lo | output | 8 | Product bits 7:0 |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | Instruction completes this cycle |
| op_cycles | output | 2 | Cycle count of the completing instruction |

## Verification
The signed operand is swept over all 256 byte values. The unsigned operand steps through 0 to 255 in strides of three, so the top, bottom and sign-crossing values are all included. The field pair changes with every operation, which separates a wrong field position or window base from a wrong product. Fixed corner pairs are added: (-128)x255, 127x255, (-1)x1, a zero operand, and both fields naming one register. These tell apart sign-extension errors in each operand, a carry taken from the wrong bit, and a zero flag that tests only one byte. A second issue held during the execute cycle, followed by idle cycles, shows whether a busy-time start is dropped and whether the flags hold.

// File: rtl/mulsu_pkg.sv
package mulsu_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_EXEC = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic carry;
      logic zero;
   } mflags_t;

endpackage

// File: rtl/mulsu_decode.sv
module mulsu_decode #(
   parameter int INSTR_W  = 16,
   parameter int ADDR_W   = 5,
   parameter int FIELD_W  = 3,
   parameter int WIN_BASE = 16,
   parameter int DST_LSB  = 4,
   parameter int SRC_LSB  = 0
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  idx_dst,
   output logic [ADDR_W-1:0]  idx_src
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

   logic [FIELD_W-1:0] fld_dst;
   logic [FIELD_W-1:0] fld_src;
   logic               unused_instr_bits;

   assign fld_dst = instr[DST_LSB +: FIELD_W];
   assign fld_src = instr[SRC_LSB +: FIELD_W];

   assign idx_dst = BASE + ADDR_W'(fld_dst);
   assign idx_src = BASE + ADDR_W'(fld_src);

   assign unused_instr_bits = ^instr;
endmodule

// File: rtl/mulsu_mult.sv
module mulsu_mult #(
   parameter int DATA_W = 8,
   parameter int IMPL   = 0
) (
   input  logic [DATA_W-1:0]   op_s,
   input  logic [DATA_W-1:0]   op_u,
   output logic [2*DATA_W-1:0] prod
);
   localparam int PROD_W = 2 * DATA_W;

   logic [PROD_W-1:0] ext_s;
   logic [PROD_W-1:0] ext_u;

   assign ext_s = {{DATA_W{op_s[DATA_W-1]}}, op_s};
   assign ext_u = {{DATA_W{1'b0}}, op_u};

   generate
      if (IMPL == 0) begin : g_direct
         assign prod = ext_s * ext_u;
      end else begin : g_array
         logic [PROD_W-1:0] pp [DATA_W];
         logic [PROD_W-1:0] acc;
         for (genvar j = 0; j < DATA_W; j++) begin : g_pp
            assign pp[j] = op_u[j] ? (ext_s << j) : '0;
         end
         always_comb begin
            acc = '0;
            for (int j = 0; j < DATA_W; j++) begin
               acc = acc + pp[j];
            end
         end
         assign prod = acc;
         logic unused_ext_u;
         assign unused_ext_u = ^ext_u;
      end
   endgenerate
endmodule

// File: rtl/mulsu_flags.sv
module mulsu_flags
   import mulsu_pkg::*;
#(
   parameter int PROD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [PROD_W-1:0] prod,
   output mflags_t           flags
);
   mflags_t nxt;

   always_comb begin
      nxt.carry = prod[PROD_W-1];
      nxt.zero  = ~|prod;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else if (upd) begin
         flags <= nxt;
      end
   end
endmodule

// File: rtl/mulsu_seq.sv
module mulsu_seq
   import mulsu_pkg::*;
#(
   parameter int LATENCY = 2,
   parameter int CYC_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             accept,
   output logic             last,
   output logic [CYC_W-1:0] cyc
);
   seq_state_e       st;
   logic [CYC_W-1:0] cnt;

   assign accept = start && (st == SEQ_IDLE);
   assign busy   = (st == SEQ_EXEC);
   assign last   = busy && (cnt == CYC_W'(LATENCY));
   assign cyc    = cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= SEQ_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            SEQ_IDLE: begin
               if (start) begin
                  st  <= SEQ_EXEC;
                  cnt <= CYC_W'(2);
               end
            end
            SEQ_EXEC: begin
               if (last) begin
                  st  <= SEQ_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               st  <= SEQ_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/mulsu_exec.sv
module mulsu_exec
   import mulsu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 32,
   parameter int INSTR_W  = 16,
   parameter int FIELD_W  = 3,
   parameter int WIN_BASE = 16,
   parameter int DST_LSB  = 4,
   parameter int SRC_LSB  = 0,
   parameter int HI_REG   = 1,
   parameter int LO_REG   = 0,
   parameter int LATENCY  = 2,
   parameter int CYC_W    = 2,
   parameter int MUL_IMPL = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [INSTR_W-1:0]          instr,
   output logic                        busy,
   output logic [$clog2(NUM_REGS)-1:0] rd_addr_a,
   output logic [$clog2(NUM_REGS)-1:0] rd_addr_b,
   input  logic [DATA_W-1:0]           rd_data_a,
   input  logic [DATA_W-1:0]           rd_data_b,
   output logic                        wr_en,
   output logic [$clog2(NUM_REGS)-1:0] wr_addr_hi,
   output logic [DATA_W-1:0]           wr_data_hi,
   output logic [$clog2(NUM_REGS)-1:0] wr_addr_lo,
   output logic [DATA_W-1:0]           wr_data_lo,
   output logic                        flag_c,
   output logic                        flag_z,
   output logic                        done,
   output logic [CYC_W-1:0]            op_cycles
);
   localparam int ADDR_W = $clog2(NUM_REGS);
   localparam int PROD_W = 2 * DATA_W;
   localparam int WIN_N  = 2 ** FIELD_W;

   generate
      if (WIN_BASE + WIN_N > NUM_REGS) begin : g_chk_window
         $error("operand window runs past the register file");
      end
      if (HI_REG == LO_REG || HI_REG >= NUM_REGS || LO_REG >= NUM_REGS) begin : g_chk_pair
         $error("destination pair must be two distinct registers");
      end
      if ((DST_LSB + FIELD_W > INSTR_W) || (SRC_LSB + FIELD_W > INSTR_W)) begin : g_chk_fields
         $error("operand field lies outside the instruction word");
      end
      if (LATENCY < 2) begin : g_chk_lat
         $error("latency must be at least two cycles");
      end
      if (CYC_W < $clog2(LATENCY + 1)) begin : g_chk_cyc
         $error("cycle count output too narrow for latency");
      end
      if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_chk_impl
         $error("unknown multiplier variant");
      end
   endgenerate

   logic              accept;
   logic              last;
   logic [DATA_W-1:0] opnd_s;
   logic [DATA_W-1:0] opnd_u;
   logic [PROD_W-1:0] product;
   mflags_t           flags;

   mulsu_decode #(
      .INSTR_W (INSTR_W),
      .ADDR_W  (ADDR_W),
      .FIELD_W (FIELD_W),
      .WIN_BASE(WIN_BASE),
      .DST_LSB (DST_LSB),
      .SRC_LSB (SRC_LSB)
   ) u_dec (
      .instr  (instr),
      .idx_dst(rd_addr_a),
      .idx_src(rd_addr_b)
   );

   mulsu_seq #(
      .LATENCY(LATENCY),
      .CYC_W  (CYC_W)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .accept(accept),
      .last  (last),
      .cyc   (op_cycles)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opnd_s <= '0;
         opnd_u <= '0;
      end else if (accept) begin
         opnd_s <= rd_data_a;
         opnd_u <= rd_data_b;
      end
   end

   mulsu_mult #(
      .DATA_W(DATA_W),
      .IMPL  (MUL_IMPL)
   ) u_mul (
      .op_s(opnd_s),
      .op_u(opnd_u),
      .prod(product)
   );

   mulsu_flags #(
      .PROD_W(PROD_W)
   ) u_flg (
      .clk  (clk),
      .rst_n(rst_n),
      .upd  (last),
      .prod (product),
      .flags(flags)
   );

   assign wr_en      = last;
   assign done       = last;
   assign wr_addr_hi = ADDR_W'(HI_REG);
   assign wr_addr_lo = ADDR_W'(LO_REG);
   assign wr_data_hi = product[PROD_W-1:DATA_W];
   assign wr_data_lo = product[DATA_W-1:0];
   assign flag_c     = flags.carry;
   assign flag_z     = flags.zero;
endmodule

// File: rtl/mulsu_exec_chk.sv
module mulsu_exec_chk #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 5,
   parameter int FIELD_W  = 3,
   parameter int WIN_BASE = 16,
   parameter int LATENCY  = 2,
   parameter int CYC_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data_hi,
   input logic [DATA_W-1:0] wr_data_lo,
   input logic              flag_c,
   input logic              flag_z,
   input logic              done,
   input logic [CYC_W-1:0]  op_cycles
);
   localparam int WIN_TOP = WIN_BASE + 2 ** FIELD_W;

   p_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (int'(rd_addr_a) >= WIN_BASE && int'(rd_addr_a) < WIN_TOP &&
                            int'(rd_addr_b) >= WIN_BASE && int'(rd_addr_b) < WIN_TOP));

   p_single_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (flag_c == $past(wr_data_hi[DATA_W-1])));

   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (flag_z == ($past(wr_data_hi) == '0 && $past(wr_data_lo) == '0)));

   p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> ($stable(flag_c) && $stable(flag_z)));

   p_done_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (op_cycles == CYC_W'(LATENCY) && busy && wr_en));

   generate
      if (LATENCY == 2) begin : g_two_cycle
         p_issue_to_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (start && !busy) |=> wr_en);
      end
   endgenerate
endmodule

bind mulsu_exec mulsu_exec_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .FIELD_W (FIELD_W),
   .WIN_BASE(WIN_BASE),
   .LATENCY (LATENCY),
   .CYC_W   (CYC_W)
) u_chk (.*);

// File: tb/sim_mulsu_exec.sv
module sim_mulsu_exec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic        busy;
   logic [4:0]  rd_addr_a;
   logic [4:0]  rd_addr_b;
   logic [7:0]  rd_data_a;
   logic [7:0]  rd_data_b;
   logic        wr_en;
   logic [4:0]  wr_addr_hi;
   logic [7:0]  wr_data_hi;
   logic [4:0]  wr_addr_lo;
   logic [7:0]  wr_data_lo;
   logic        flag_c;
   logic        flag_z;
   logic        done;
   logic [1:0]  op_cycles;

   logic [7:0] rf     [32];
   logic [7:0] exp_rf [32];

   int n_chk  = 0;
   int n_fail = 0;
   int cyc_n  = 0;

   always #5 clk = ~clk;

   assign rd_data_a = rf[rd_addr_a];
   assign rd_data_b = rf[rd_addr_b];

   mulsu_exec u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .instr     (instr),
      .busy      (busy),
      .rd_addr_a (rd_addr_a),
      .rd_addr_b (rd_addr_b),
      .rd_data_a (rd_data_a),
      .rd_data_b (rd_data_b),
      .wr_en     (wr_en),
      .wr_addr_hi(wr_addr_hi),
      .wr_data_hi(wr_data_hi),
      .wr_addr_lo(wr_addr_lo),
      .wr_data_lo(wr_data_lo),
      .flag_c    (flag_c),
      .flag_z    (flag_z),
      .done      (done),
      .op_cycles (op_cycles)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_n <= cyc_n + 1;
      if (cyc_n > 150000) begin
         chk(1'b0, "watchdog", cyc_n, 150000);
         report();
      end
   end

   task automatic set_reg(input int idx, input logic [7:0] v);
      rf[idx]     = v;
      exp_rf[idx] = v;
   endtask

   function automatic logic [15:0] mk_instr(input logic [2:0] d, input logic [2:0] s);
      return {8'h03, 1'b0, d, 1'b0, s};
   endfunction

   // Called at a falling edge; returns at the falling edge after the write cycle.
   task automatic mul_op(input logic [2:0] d, input logic [2:0] s, input bit hold_start);
      logic [7:0]  a;
      logic [7:0]  b;
      int          p;
      logic [15:0] ep;
      logic [31:0] mism;
      a  = rf[16 + int'(d)];
      b  = rf[16 + int'(s)];
      p  = int'($signed(a)) * int'(b);
      ep = p[15:0];
      instr = mk_instr(d, s);
      start = 1'b1;
      #1;
      // R1: read addresses from the operand fields
      chk(rd_addr_a == 5'(16 + int'(d)) && rd_addr_b == 5'(16 + int'(s)), "R1 read addresses",
          {rd_addr_a, rd_addr_b}, {5'(16 + int'(d)), 5'(16 + int'(s))});
      @(negedge clk);
      if (hold_start) begin
         instr = mk_instr(d + 3'd1, s + 3'd2);
         start = 1'b1;
      end else begin
         start = 1'b0;
      end
      // R3 / R7: single write cycle, fixed pair, done with count
      chk(wr_en && wr_addr_hi == 5'd1 && wr_addr_lo == 5'd0, "R3 write pulse and pair",
          {wr_en, wr_addr_hi, wr_addr_lo}, {1'b1, 5'd1, 5'd0});
      chk(done && busy && op_cycles == 2'd2, "R7 two-cycle completion",
          {done, busy, op_cycles}, {1'b1, 1'b1, 2'd2});
      // R2: signed times unsigned product
      chk({wr_data_hi, wr_data_lo} == ep, "R2 product", {wr_data_hi, wr_data_lo}, ep);
      if (wr_en) begin
         rf[wr_addr_hi] = wr_data_hi;
         rf[wr_addr_lo] = wr_data_lo;
      end
      exp_rf[1] = ep[15:8];
      exp_rf[0] = ep[7:0];
      @(negedge clk);
      if (hold_start) begin
         start = 1'b0;
         #1;
      end
      // R4 / R5: flags after the write cycle
      chk(flag_c == ep[15], "R4 carry", flag_c, ep[15]);
      chk(flag_z == (ep == 16'd0), "R5 zero", flag_z, (ep == 16'd0));
      chk(!wr_en && !done, "R3 no second write", {wr_en, done}, 0);
      mism = 0;
      for (int i = 0; i < 32; i++) begin
         if (rf[i] !== exp_rf[i]) mism++;
      end
      chk(mism == 0, "R10 register file untouched", mism, 0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin
         set_reg(i, 8'(i * 7 + 3));
      end
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(!busy && !wr_en && !done && !flag_c && !flag_z && op_cycles == 2'd0, "R9 reset state",
          {busy, wr_en, done, flag_c, flag_z, op_cycles}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: most negative signed operand times largest unsigned
      set_reg(21, 8'h80);
      set_reg(18, 8'hFF);
      mul_op(3'd5, 3'd2, 1'b0);
      chk({rf[1], rf[0]} == 16'h8080 && flag_c && !flag_z, "R11 -128x255",
          {rf[1], rf[0], flag_c, flag_z}, {16'h8080, 1'b1, 1'b0});

      // Corner pairs for R2, R4, R5
      set_reg(16, 8'h7F); set_reg(23, 8'hFF); mul_op(3'd0, 3'd7, 1'b0);
      set_reg(17, 8'hFF); set_reg(19, 8'h01); mul_op(3'd1, 3'd3, 1'b0);
      set_reg(20, 8'h00); set_reg(22, 8'hA5); mul_op(3'd4, 3'd6, 1'b0);
      set_reg(22, 8'h9C); set_reg(20, 8'h00); mul_op(3'd6, 3'd4, 1'b0);
      // R2: both fields name one register
      set_reg(19, 8'h80); mul_op(3'd3, 3'd3, 1'b0);
      set_reg(19, 8'hFF); mul_op(3'd3, 3'd3, 1'b0);

      // R8 / R6: start held during the execute cycle is dropped, flags hold
      set_reg(16, 8'hF0); set_reg(17, 8'h10);
      mul_op(3'd0, 3'd1, 1'b1);
      begin
         logic c0, z0;
         c0 = flag_c;
         z0 = flag_z;
         chk(!busy && !wr_en, "R8 busy-time start ignored", {busy, wr_en}, 0);
         repeat (3) begin
            @(negedge clk);
            chk(!wr_en && !busy, "R8 no late write", {wr_en, busy}, 0);
            chk(flag_c == c0 && flag_z == z0, "R6 flags hold", {flag_c, flag_z}, {c0, z0});
         end
      end

      // Sweep: all signed values, unsigned in strides of three, fields varying (R1, R2)
      for (int a = 0; a < 256; a++) begin
         for (int bi = 0; bi < 86; bi++) begin
            logic [2:0] d;
            logic [2:0] s;
            d = 3'(a);
            s = 3'((int'(d) + 1 + (bi % 7)) % 8);
            set_reg(16 + int'(d), 8'(a));
            set_reg(16 + int'(s), 8'(bi * 3));
            mul_op(d, s, 1'b0);
         end
      end

      report();
   end
endmodule